// File: doc/BRIEF.md
# Card Controller Status and Interrupt Unit

This block keeps the status word of a memory-card host controller and turns it into two interrupt lines. The low eleven bits of the status word are sticky event flags. The command and data engines raise them with one-cycle set pulses. The upper bits are live level flags that the data engine drives straight through. Each interrupt line has its own 32-bit enable mask. A line is asserted when any status bit that its mask selects is set. Software acknowledges events by writing ones to a clear register. That register reaches only the sticky field.

The unit also contains a read-deferral interlock. When software pops a word from the FIFO data window, the unit raises `xfer_hold`. This stops the data engine from moving more bytes between the card and the FIFO. The hold stays up until software reads either the status register or the FIFO-count register. That read returns its value unchanged. The hold then drops, and `xfer_kick` pulses once so that the data engine resumes. The FIFO-count register itself belongs to the data engine: this unit only watches reads of its address and returns zero for it.

Register offsets are byte addresses, 32-bit aligned:
- 0x34: status (read)
- 0x38: clear (write)
- 0x3C: mask for `irq[0]`
- 0x40: mask for `irq[1]`
- 0x48: FIFO count (read, watched only)
- 0x80 to 0xBC: FIFO data window

Top module: `sdmci_irq_status`

## Requirements
- R1: `irq[i]` is registered. It is high in the cycle after a clock edge at which (status AND mask i) is nonzero, and low otherwise. The two lanes are independent. A live status flag therefore reaches its interrupt after one edge, and a sticky event after two.
- R2: A write to offset 0x38 clears each sticky status bit [10:0] whose written bit is 1. Written bits [31:11] have no effect.
- R3: Sticky bits 0..8 and 10 are set by a pulse on the matching `evt_set` bit and stay set until cleared. Bit 9 is reserved and always reads 0, even when it is pulsed.
- R4: When a set pulse and a clear write hit the same sticky bit in the same cycle, the bit ends up set.
- R5: A read of offset 0x34 returns {`live_flags`, sticky[10:0]}, with the live flags in bits [31:11]. Reads of 0x3C and 0x40 return the masks. Any other offset reads as 0.
- R6: A read at a word offset from 0x80 to 0xBC while `fifo_has_word` is 1 raises `xfer_hold` from the next cycle. A read outside that window, or one made while the FIFO is empty, leaves `xfer_hold` unchanged.
- R7: While `xfer_hold` is 1, a read of 0x34 or 0x48 returns its current value. `xfer_hold` drops on the next edge, and `xfer_kick` is 1 for exactly that one cycle. The same read made without a hold gives no kick.
- R8: Reset (synchronous, active high) clears the sticky bits, both masks, `xfer_hold`, `xfer_kick` and both interrupts.
- R9: Writes to read-only or unmapped offsets, such as 0x34 or 0x44, change neither the status word nor the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the registers owned here, 0 for all others |
| evt_set | input | 11 | One-cycle set pulses for sticky status bits [10:0] |
| live_flags | input | 21 | Level flags shown as status bits [31:11] |
| fifo_has_word | input | 1 | FIFO holds at least one word |
| irq | output | 2 | Masked interrupt lines |
| xfer_hold | output | 1 | Card-to-FIFO data movement is held off |
| xfer_kick | output | 1 | One-cycle pulse that restarts data movement |

## Verification
The bench counts clock edges to interrupt assertion. A sticky event must take two edges and a live flag one, so an unregistered line shows up early and a double-registered line shows up late.

It clears and sets the same bit in one cycle. It writes ones above bit 10 of the clear register, and it pulses the reserved bit. A design with the wrong priority would lose the event. A design with the wrong clear width would disturb the live flags, and a design without the reserved-bit rule would read bit 9 back as 1.

For the interlock, the bench pops one word at each edge of the window and tries one just past it. It also pops from an empty FIFO. It releases the hold once through each of the two release addresses, and it reads status once with no hold. A faulty interlock would hold on the wrong reads, never release, or pulse the kick without a hold.

// File: rtl/sdmci_stat_pkg.sv
package sdmci_stat_pkg;

    localparam int STAT_W   = 32;
    localparam int STICKY_W = 11;
    localparam int LIVE_W   = STAT_W - STICKY_W;
    localparam int ADDR_W   = 12;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_MASK0  = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_FCOUNT = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_WIN_LO = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_WIN_HI = 12'h0BC;

    // sticky bits that exist; bit 9 is reserved
    localparam logic [STICKY_W-1:0] STICKY_IMPL = 11'b101_1111_1111;

    typedef enum logic {
        DEF_FREE = 1'b0,
        DEF_HELD = 1'b1
    } defer_st_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [STAT_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [ADDR_W-1:0] mask_ofs(input int lane);
        return OFS_MASK0 + ADDR_W'(4 * lane);
    endfunction

    function automatic logic in_fifo_window(input logic [ADDR_W-1:0] a);
        return (a >= OFS_WIN_LO) && (a <= OFS_WIN_HI) && (a[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/sdmci_sticky_bank.sv
module sdmci_sticky_bank
    import sdmci_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STICKY_W-1:0] set_i,
    input  logic [STICKY_W-1:0] clr_i,
    output logic [STICKY_W-1:0] sticky_o
);

    logic [STICKY_W-1:0] sticky_q;
    logic [STICKY_W-1:0] set_eff;

    assign set_eff  = set_i & STICKY_IMPL;
    assign sticky_o = sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
        end else begin
            // a set in the same cycle overrides a clear
            sticky_q <= ((sticky_q & ~clr_i) | set_eff) & STICKY_IMPL;
        end
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_eff) |=> ((sticky_q & $past(set_eff)) == $past(set_eff)));

    // R2
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_eff)) |=> ((sticky_q & $past(clr_i & ~set_eff)) == '0));

    // R3
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((~sticky_q & $past(sticky_q)) == '0));

endmodule

// File: rtl/sdmci_irq_lane.sv
module sdmci_irq_lane
    import sdmci_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h03C
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);

    logic [STAT_W-1:0] mask_q;
    logic              irq_q;
    logic              mask_we;

    assign mask_we = req_i.wr && (req_i.addr == MASK_OFS);
    assign mask_o  = mask_q;
    assign irq_o   = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (mask_we) begin
                mask_q <= req_i.wdata;
            end
            irq_q <= |(stat_i & mask_q);
        end
    end

    // R1
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_we && req_i.wdata == '0) |=> ##1 !irq_o);

    // R1
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq_o);

endmodule

// File: rtl/sdmci_read_defer.sv
module sdmci_read_defer
    import sdmci_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pop_i,
    input  logic release_i,
    output logic hold_o,
    output logic kick_o
);

    defer_st_e st_q, st_d;
    logic      kick_q;
    logic      do_release;

    assign do_release = (st_q == DEF_HELD) && release_i && !pop_i;

    always_comb begin
        st_d = st_q;
        if (pop_i) begin
            st_d = DEF_HELD;
        end else if (do_release) begin
            st_d = DEF_FREE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DEF_FREE;
            kick_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            kick_q <= do_release;
        end
    end

    assign hold_o = (st_q == DEF_HELD);
    assign kick_o = kick_q;

    // R6
    pop_holds_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |=> hold_o);

    // R7
    release_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_o && release_i && !pop_i) |=> (!hold_o && kick_o));

    // R7
    kick_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_o) |=> !kick_o);

endmodule

// File: rtl/sdmci_irq_status.sv
module sdmci_irq_status
    import sdmci_stat_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [STAT_W-1:0]   reg_wdata,
    output logic [STAT_W-1:0]   reg_rdata,
    input  logic [STICKY_W-1:0] evt_set,
    input  logic [LIVE_W-1:0]   live_flags,
    input  logic                fifo_has_word,
    output logic [N_IRQ-1:0]    irq,
    output logic                xfer_hold,
    output logic                xfer_kick
);

    reg_req_t            req;
    logic [STICKY_W-1:0] clr_bits;
    logic [STICKY_W-1:0] sticky;
    logic [STAT_W-1:0]   status_word;
    logic [STAT_W-1:0]   lane_mask [N_IRQ];
    logic                fifo_pop;
    logic                defer_release;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};

    assign clr_bits = (req.wr && req.addr == OFS_CLEAR) ? req.wdata[STICKY_W-1:0] : '0;

    assign fifo_pop      = req.rd && in_fifo_window(req.addr) && fifo_has_word;
    assign defer_release = req.rd && (req.addr == OFS_STATUS || req.addr == OFS_FCOUNT);

    sdmci_sticky_bank u_sticky (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt_set),
        .clr_i    (clr_bits),
        .sticky_o (sticky)
    );

    assign status_word = {live_flags, sticky};

    for (genvar g = 0; g < N_IRQ; g++) begin : g_lane
        sdmci_irq_lane #(
            .MASK_OFS (mask_ofs(g))
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .req_i  (req),
            .stat_i (status_word),
            .mask_o (lane_mask[g]),
            .irq_o  (irq[g])
        );
    end

    sdmci_read_defer u_defer (
        .clk       (clk),
        .rst       (rst),
        .pop_i     (fifo_pop),
        .release_i (defer_release),
        .hold_o    (xfer_hold),
        .kick_o    (xfer_kick)
    );

    always_comb begin
        reg_rdata = '0;
        if (req.addr == OFS_STATUS) begin
            reg_rdata = status_word;
        end
        for (int i = 0; i < N_IRQ; i++) begin
            if (req.addr == mask_ofs(i)) begin
                reg_rdata = lane_mask[i];
            end
        end
    end

    // R9
    status_not_writable_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_STATUS && evt_set == '0) |=>
            ((~sticky & $past(sticky)) == '0 && (sticky & ~$past(sticky)) == '0));

endmodule

// File: tb/sdmci_irq_status_bench.sv
module sdmci_irq_status_bench;
    import sdmci_stat_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic                reg_wr, reg_rd;
    logic [ADDR_W-1:0]   reg_addr;
    logic [STAT_W-1:0]   reg_wdata;
    logic [STAT_W-1:0]   reg_rdata;
    logic [STICKY_W-1:0] evt_set;
    logic [LIVE_W-1:0]   live_flags;
    logic                fifo_has_word;
    logic [1:0]          irq;
    logic                xfer_hold, xfer_kick;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sdmci_irq_status u_sdmci_irq_status (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_set(evt_set), .live_flags(live_flags), .fifo_has_word(fifo_has_word),
        .irq(irq), .xfer_hold(xfer_hold), .xfer_kick(xfer_kick)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [10:0] s);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_set = s;
        @(negedge clk);
        reg_wr = 1'b0; evt_set = '0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [10:0] s);
        @(negedge clk);
        evt_set = s;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 12'h000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        pulse(11'h1FF);
        wr(12'h03C, 32'hFFFF_FFFF, '0);
        fifo_has_word = 1'b1;
        rd(12'h080, v);
        fifo_has_word = 1'b0;
        do_reset();
        check("R8 hold", {31'd0, xfer_hold}, 32'd0);
        check("R8 kick", {31'd0, xfer_kick}, 32'd0);
        check("R8 irq",  {30'd0, irq}, 32'd0);
        rd(12'h034, v); check("R8 status", v, 32'd0);
        rd(12'h03C, v); check("R8 mask0", v, 32'd0);
        rd(12'h040, v); check("R8 mask1", v, 32'd0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        live_flags = 21'h12345;
        pulse(11'h7FF);
        rd(12'h034, v); check("R3 set incl reserved bit9", v, {21'h12345, 11'h5FF});
        rd(12'h034, v); check("R3 held", v, {21'h12345, 11'h5FF});
        rd(12'h044, v); check("R5 unmapped reads 0", v, 32'd0);
        wr(12'h038, 32'hFFFF_F003, '0);
        rd(12'h034, v); check("R2 clear low only", v, {21'h12345, 11'h5FC});
        wr(12'h038, 32'h0000_0020, 11'h010);
        wr(12'h038, 32'h0000_0010, 11'h010);
        rd(12'h034, v); check("R4 set beats clear", v, {21'h12345, 11'h5DC});
        wr(12'h038, 32'h0000_07FF, '0);
        rd(12'h034, v); check("R2 clear all", v, {21'h12345, 11'h000});
        live_flags = '0;
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(12'h03C, 32'h0000_0100, '0);
        wr(12'h040, 32'h0000_1000, '0);
        rd(12'h03C, v); check("R5 mask0 read", v, 32'h0000_0100);
        rd(12'h040, v); check("R5 mask1 read", v, 32'h0000_1000);
        check("R1 idle", {30'd0, irq}, 32'd0);
        pulse(11'h100);
        check("R1 irq0 not yet", {31'd0, irq[0]}, 32'd0);
        @(negedge clk);
        check("R1 irq0 after two edges", {30'd0, irq}, 32'd1);
        live_flags = 21'h000002;
        @(negedge clk);
        check("R1 irq1 after one edge", {30'd0, irq}, 32'd3);
        wr(12'h038, 32'h0000_0100, '0);
        check("R1 irq0 lingers one cycle", {31'd0, irq[0]}, 32'd1);
        @(negedge clk);
        check("R1 irq0 drops", {30'd0, irq}, 32'd2);
        live_flags = '0;
        @(negedge clk);
        check("R1 irq1 drops", {30'd0, irq}, 32'd0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        pulse(11'h001);
        wr(12'h034, 32'h0000_0000, '0);
        wr(12'h044, 32'hFFFF_FFFF, '0);
        rd(12'h034, v); check("R9 status unwritable", v, 32'h0000_0001);
        rd(12'h03C, v); check("R9 mask0 kept", v, 32'h0000_0100);
        rd(12'h040, v); check("R9 mask1 kept", v, 32'h0000_1000);
        wr(12'h038, 32'h0000_0001, '0);
    endtask

    task automatic t_defer();
        logic [31:0] v;
        fifo_has_word = 1'b0;
        rd(12'h080, v); check("R6 empty pop no hold", {31'd0, xfer_hold}, 32'd0);
        fifo_has_word = 1'b1;
        rd(12'h0C0, v); check("R6 outside window no hold", {31'd0, xfer_hold}, 32'd0);
        rd(12'h034, v); check("R7 no kick without hold", {31'd0, xfer_kick}, 32'd0);
        rd(12'h0BC, v); check("R6 pop raises hold", {31'd0, xfer_hold}, 32'd1);
        pulse(11'h001);
        check("R6 hold persists", {31'd0, xfer_hold}, 32'd1);
        rd(12'h034, v); check("R7 status read value", v, 32'h0000_0001);
        check("R7 hold drops", {31'd0, xfer_hold}, 32'd0);
        check("R7 kick pulse", {31'd0, xfer_kick}, 32'd1);
        @(negedge clk);
        check("R7 kick one cycle", {31'd0, xfer_kick}, 32'd0);
        rd(12'h080, v); check("R6 low edge pop", {31'd0, xfer_hold}, 32'd1);
        rd(12'h048, v); check("R7 fcount read releases", {30'd0, xfer_kick, xfer_hold}, 32'd2);
        fifo_has_word = 1'b0;
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        evt_set = '0; live_flags = '0; fifo_has_word = 1'b0;
        do_reset();
        t_reset();
        t_sticky();
        t_irq();
        t_ignored();
        t_defer();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule